// File: doc/BRIEF.md
# SPI Master with Prescaled Serial Clock

This block is a byte-wide serial peripheral interface master driven by a host through a small register port. The host sets the clock polarity, clock phase and a two-bit rate code in a control register, then writes a byte to the data address. The byte goes straight into the shift register when the shifter is idle. Otherwise it waits in a one-entry transmit buffer until the current transfer finishes. Each transfer shifts eight bits out on `mosi_o`, most significant bit first, and shifts eight bits in from `miso_i` on the same serial clock edges.

When a transfer completes, the received byte is copied into a receive data register and a receive-full flag is raised. The host clears that flag with a two-step handshake: a status read, then a data read as the very next register access. A byte that completes while the flag is still set is dropped and raises an overflow flag. Two interrupt lines report transmitter-empty and receiver-full, each gated by its own enable bit.

Register map: address 0 is control, with cpol in bit 0, cpha in bit 1, rate in bits 3:2, rx interrupt enable in bit 4 and tx interrupt enable in bit 5. Address 1 is status, with tx_empty in bit 0, rx_full in bit 1 and overflow in bit 2. Address 2 is data: a write loads the transmit byte and a read returns the receive byte. `rdata_o` is combinational on `addr_i`, and an access lasts one cycle with `req_i` high.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, status reads 3'b001 (tx_empty set, rx_full and overflow clear), control reads 0, `sck_o` and `mosi_o` are 0, and both interrupt lines are low.
- R2: During a transfer, `sck_o` toggles every 2^(2*rate) bus cycles, so the serial clock is the bus clock divided by 2, 8, 32 or 128 for rate codes 0 to 3.
- R3: When idle, `sck_o` equals cpol. A transfer makes exactly 16 toggles of `sck_o`, so the clock ends at its idle level. Data is sampled on rising edges when cpol equals cpha and on falling edges otherwise.
- R4: The bits on `mosi_o` at the sampling edges are the written byte, most significant bit first.
- R5: Full duplex: the byte received is the value `miso_i` holds at the eight sampling edges, first bit into the MSB.
- R6: A data write while tx_empty is set and the shifter is idle starts a transfer at once, and tx_empty stays set.
- R7: A data write while a transfer runs fills the buffer and clears tx_empty. When the shifter frees, the buffer moves in and tx_empty sets again. A data write while tx_empty is clear is ignored.
- R8: At the end of a transfer, rx_full sets and the received byte appears in the receive data register.
- R9: rx_full and overflow are cleared only by a data read whose previous register access was a status read that saw rx_full set. A data read without that status read leaves rx_full set.
- R10: A transfer that completes while rx_full is set sets overflow and leaves the receive data register unchanged.
- R11: Any write to the data address clears the tx interrupt enable bit.
- R12: `irq_tx_o` is high exactly when the tx interrupt enable bit and tx_empty are both set. `irq_rx_o` is high exactly when the rx interrupt enable bit and rx_full are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_tx_o | output | 1 | Transmitter-empty interrupt |
| irq_rx_o | output | 1 | Receiver-full interrupt |

## Verification
The bench sweeps all four polarity and phase modes across all four rate codes, using looped-back and inverted-looped-back data. A swapped sampling edge or bit order shows up as a corrupted received byte or captured MOSI byte. A wrong divider shows up as a toggle interval other than 2^(2*rate), and a miscounted bit shows up as a toggle count other than 16. Back-to-back writes test the buffer: a third write that is not ignored would add a third transfer, and a buffer that does not move would leave tx_empty clear. The flag tests check that a data read without the status read does not clear rx_full, that an overrun keeps the first byte and sets overflow, and that a data write drops the tx interrupt.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int unsigned RATE_W = 2;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  // packed MSB first: tx_ie=bit5 ... cpol=bit0
  typedef struct packed {
    logic              tx_ie;
    logic              rx_ie;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_host_prescale.sv
module spi_host_prescale #(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int unsigned MAX_SH = 2 * ((1 << RATE_W) - 1);
  localparam int unsigned CNT_W  = (MAX_SH > 0) ? MAX_SH : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // half period minus one = 2^(2*rate) - 1
  assign lim    = ~({CNT_W{1'b1}} << {rate_i, 1'b0});
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int unsigned EDGE_W = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST = EDGE_W'(2 * DATA_W - 1);

  logic              busy_q, done_q, sck_q, mosi_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic              samp;

  assign samp = (edge_q[0] == cpha_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      edge_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        sck_q  <= cpol_i;
        if (cpha_i) begin
          tx_sr <= tx_byte_i;
        end else begin
          tx_sr  <= tx_byte_i << 1;
          mosi_q <= tx_byte_i[DATA_W-1];
        end
      end else if (busy_q && tick_i) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + 1'b1;
        if (samp) begin
          rx_sr <= {rx_sr[DATA_W-2:0], miso_i};
        end else begin
          mosi_q <= tx_sr[DATA_W-1];
          tx_sr  <= tx_sr << 1;
        end
        if (edge_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign sck_o     = busy_q ? sck_q : cpol_i;
  assign mosi_o    = mosi_q;
  assign rx_byte_o = rx_sr;
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_tx_o,
  output logic              irq_rx_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] buf_q, rx_data_q, tx_sel, rx_byte;
  logic              tx_empty_q, rx_full_q, ovf_q, armed_q;
  logic              wr_ctrl, wr_data, rd_stat, rd_data, clr_rx;
  logic              busy, done, tick, start, load_buf, load_now;

  assign wr_ctrl = req_i &&  we_i && (addr_i == ADDR_CTRL);
  assign wr_data = req_i &&  we_i && (addr_i == ADDR_DATA);
  assign rd_stat = req_i && !we_i && (addr_i == ADDR_STAT);
  assign rd_data = req_i && !we_i && (addr_i == ADDR_DATA);
  assign clr_rx  = rd_data && armed_q;

  assign load_buf = !tx_empty_q && !busy;
  assign load_now = wr_data && tx_empty_q && !busy;
  assign start    = load_buf || load_now;
  assign tx_sel   = load_buf ? buf_q : wdata_i;

  spi_host_prescale #(.RATE_W(RATE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .rate_i (ctrl_q.rate),
    .tick_o (tick)
  );

  spi_host_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .tx_byte_i (tx_sel),
    .cpol_i    (ctrl_q.cpol),
    .cpha_i    (ctrl_q.cpha),
    .tick_i    (tick),
    .miso_i    (miso_i),
    .busy_o    (busy),
    .done_o    (done),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o),
    .rx_byte_o (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      buf_q      <= '0;
      tx_empty_q <= 1'b1;
    end else begin
      if (wr_ctrl)      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      else if (wr_data) ctrl_q.tx_ie <= 1'b0;
      if (load_buf) begin
        tx_empty_q <= 1'b1;
      end else if (wr_data && tx_empty_q && busy) begin
        buf_q      <= wdata_i;
        tx_empty_q <= 1'b0;
      end
    end
  end

  // receive side: clear handshake first, completion overrides
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0;
      rx_full_q <= 1'b0;
      ovf_q     <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (req_i) armed_q <= rd_stat && rx_full_q;
      if (clr_rx) begin
        rx_full_q <= 1'b0;
        ovf_q     <= 1'b0;
      end
      if (done) begin
        if (rx_full_q && !clr_rx) begin
          ovf_q <= 1'b1;
        end else begin
          rx_data_q <= rx_byte;
          rx_full_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = DATA_W'(ctrl_q);
      ADDR_STAT: rdata_o = DATA_W'({ovf_q, rx_full_q, tx_empty_q});
      ADDR_DATA: rdata_o = rx_data_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_tx_o = ctrl_q.tx_ie && tx_empty_q;
  assign irq_rx_o = ctrl_q.rx_ie && rx_full_q;
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              done,
  input logic              wr_data,
  input logic              clr_rx,
  input logic              tx_empty_q,
  input logic              rx_full_q,
  input logic              ovf_q,
  input logic [DATA_W-1:0] rx_data_q,
  input logic              irq_tx_o
);
  a_r11_txie_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> !irq_tx_o);

  a_r10_ovf_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rx_full_q && !clr_rx) |=> (ovf_q && $stable(rx_data_q)));

  a_r9_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_q && !clr_rx) |=> rx_full_q);

  a_r7_buffer_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_empty_q && !busy) |=> (busy && tx_empty_q));

  a_r8_done_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rx_full_q);
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy       (busy),
  .done       (done),
  .wr_data    (wr_data),
  .clr_rx     (clr_rx),
  .tx_empty_q (tx_empty_q),
  .rx_full_q  (rx_full_q),
  .ovf_q      (ovf_q),
  .rx_data_q  (rx_data_q),
  .irq_tx_o   (irq_tx_o)
);

// File: tb/spi_host_ctrl_tb_top.sv
module spi_host_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, mosi, miso, irq_tx, irq_rx;
  logic       inv = 1'b0;

  int total = 0, bad = 0, cyc = 0;
  int edges = 0, gap = 0, gap_bad = 0, exp_half = 1;
  logic [7:0] cap = '0;
  logic       sck_prev = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;

  always #2 clk = ~clk;

  assign miso = inv ? ~mosi : mosi;

  spi_host_ctrl #(.DATA_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .irq_tx_o(irq_tx), .irq_rx_o(irq_rx)
  );

  // serial clock monitor
  always @(negedge clk) begin
    if (sck !== sck_prev) begin
      if (edges > 0 && gap != exp_half) gap_bad++;
      edges++;
      gap = 1;
      if ((sck == 1'b1) == (m_cpol == m_cpha)) cap = {cap[6:0], mosi};
    end else begin
      gap++;
    end
    sck_prev = sck;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic mon_reset();
    @(posedge clk);
    edges = 0; gap = 0; gap_bad = 0; cap = '0;
  endtask

  task automatic wait_full();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(2'd1, s);
      if (s[1]) return;
    end
    chk(1'b0, "wait rx_full", 0, 1);
  endtask

  task automatic run_xfer(input bit pol, input bit pha, input int rate,
                          input logic [7:0] b, input bit iv);
    logic [7:0] d;
    m_cpol = pol; m_cpha = pha; exp_half = 1 << (2 * rate);
    reg_wr(2'd0, {2'b00, 2'(rate), pha, pol});
    mon_reset();
    inv = iv;
    reg_wr(2'd2, b);
    wait_full();
    chk(edges == 16, "R3 toggle count", edges, 16);
    chk(gap_bad == 0, "R2 half period", gap_bad, 0);
    chk(cap == b, "R4 mosi msb first", cap, b);
    chk(sck == pol, "R3 idle level", sck, pol);
    reg_rd(2'd2, d);
    chk(d == (b ^ {8{iv}}), "R5 R8 rx byte", d, b ^ {8{iv}});
    reg_rd(2'd1, d);
    chk(d[1] == 1'b0, "R9 cleared", d[1], 0);
  endtask

  initial begin
    logic [7:0] d;
    #1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(sck == 1'b0 && mosi == 1'b0, "R1 pins", {sck, mosi}, 0);
    chk(irq_tx == 1'b0 && irq_rx == 1'b0, "R1 irqs", {irq_tx, irq_rx}, 0);
    reg_rd(2'd1, d);
    chk(d == 8'h01, "R1 status", d, 8'h01);
    reg_rd(2'd0, d);
    chk(d == 8'h00, "R1 ctrl", d, 0);

    // R2 R3 R4 R5 sweep
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++) begin
        run_xfer(m[0], m[1], r, 8'hA5 ^ 8'(m * 16 + r), 1'b0);
        run_xfer(m[0], m[1], r, 8'h3C + 8'(r), 1'b1);
      end

    // R6 R7 R10: buffering and overrun, mode 0 rate 0
    m_cpol = 0; m_cpha = 0; exp_half = 1; inv = 0;
    reg_wr(2'd0, 8'h00);
    mon_reset();
    reg_wr(2'd2, 8'h5A);
    reg_rd(2'd1, d);
    chk(d[0] == 1'b1, "R6 tx_empty after direct load", d[0], 1);
    reg_wr(2'd2, 8'hC3);
    reg_rd(2'd1, d);
    chk(d[0] == 1'b0, "R7 buffer full", d[0], 0);
    reg_wr(2'd2, 8'hFF);
    wait_full();
    reg_rd(2'd1, d);
    chk(d[0] == 1'b1, "R7 buffer moved", d[0], 1);
    repeat (40) @(negedge clk);
    reg_rd(2'd1, d);
    chk(d[2:1] == 2'b11, "R10 overflow", d[2:1], 3);
    reg_rd(2'd2, d);
    chk(d == 8'h5A, "R10 data kept", d, 8'h5A);
    repeat (60) @(negedge clk);
    reg_rd(2'd1, d);
    chk(d[2:0] == 3'b001, "R9 R7 cleared, third write ignored", d[2:0], 1);
    chk(edges == 32 && cap == 8'hC3, "R7 two transfers only", edges, 32);

    // R9 R11 R12
    reg_wr(2'd0, 8'h30);
    chk(irq_tx == 1'b1 && irq_rx == 1'b0, "R12 irq_tx", {irq_tx, irq_rx}, 2);
    reg_wr(2'd2, 8'h81);
    chk(irq_tx == 1'b0, "R11 irq_tx dropped", irq_tx, 0);
    reg_rd(2'd0, d);
    chk(d == 8'h10, "R11 tx_ie cleared", d, 8'h10);
    wait_full();
    chk(irq_rx == 1'b1, "R12 irq_rx", irq_rx, 1);
    reg_rd(2'd0, d);
    reg_rd(2'd2, d);
    chk(d == 8'h81, "R8 data", d, 8'h81);
    reg_rd(2'd1, d);
    chk(d[1] == 1'b1, "R9 data read alone keeps full", d[1], 1);
    reg_rd(2'd2, d);
    reg_rd(2'd1, d);
    chk(d[1] == 1'b0 && irq_rx == 1'b0, "R9 R12 handshake clears", {d[1], irq_rx}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule